// File: doc/BRIEF.md
# External Pin Interrupt Controller

This block turns two external request pins into interrupt requests for a small microcontroller core. Each pin first passes through a two-flop synchroniser. A 2-bit sense field then sets how that pin is read. In the two edge modes, a detected edge of the chosen polarity latches a pending flag. In low-level mode, the synchronised low level raises a request directly, and no flag is kept.

The block owns an enable mask register and a pending flag register, both on a narrow I/O bus with one address per register. A pending source raises a request only when its mask bit and the core's global interrupt enable are both set. When several sources are requesting, the lowest-numbered one is presented on the vector output. An acknowledge from the core clears the flag of the source being presented. Software can also clear a flag by writing 1 to its bit.

The pins are observed whatever the port direction is. Activity that the chip itself drives onto a pin therefore raises requests like any other input.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After a synchronous reset, both the mask and the flag register read 0x00, irq_o is 0 and vec_o is 0.
- R2: The mask register is at I/O address 0x3B and the flag register is at 0x3A. In both registers, bit 7 belongs to source 1 and bit 6 belongs to source 0. Bits 5..0 always read 0. Any other address reads 0x00. A write to 0x3B loads mask bits 7..6.
- R3: Source i takes its sense field from sense_i[2i+1:2i]. The field values are 00 = low level, 01 = reserved, 10 = falling edge and 11 = rising edge.
- R4: In an edge mode, a pin edge of the selected polarity makes the flag bit read 1 from the third rising clock edge after the pin changes. This happens whether or not the source is masked.
- R5: In low-level mode, the source requests while its synchronised pin is 0. The request is seen from the second rising clock edge after the pin changes. The flag bit stays 0.
- R6: In reserved mode (01), the source never requests and its flag stays 0.
- R7: irq_o is 1 only when gie_i is 1 and the mask bit of a pending source is 1.
- R8: Writing 1 to a flag bit at 0x3A clears that flag. Writing 0 leaves the flag unchanged. If a new edge arrives in the same cycle as a clear, the flag stays set.
- R9: ack_i clears only the flag of the source currently shown on vec_o. Other flags are left as they are.
- R10: vec_o is 1 for source 0 and 2 for source 1. Source 0 wins when both request. vec_o is 0 when irq_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 2 | Raw external request pins, bit i is source i |
| sense_i | input | 4 | Sense field per source, two bits each |
| gie_i | input | 1 | Global interrupt enable from the core |
| ack_i | input | 1 | Core has taken the presented interrupt |
| io_wr_i | input | 1 | I/O write strobe |
| io_addr_i | input | 6 | I/O address |
| io_wdata_i | input | 8 | I/O write data |
| io_rdata_o | output | 8 | I/O read data for io_addr_i |
| irq_o | output | 1 | Interrupt request to the core |
| vec_o | output | 2 | Vector number of the winning source, 0 when idle |

## Verification
The hardest case to reach from the ports is a flag clear that lands in the same cycle as a fresh edge on the same pin. Because of the three-cycle pin-to-flag latency, it needs a write or acknowledge timed against a pin change made two cycles earlier. A long random phase reaches it: pins toggle often, and writes, acknowledges and sense changes are frequent. Every cycle is compared against a cycle-accurate bench model. Directed sequences cover the fixed cases first: masked latching, write-0, acknowledge with both sources pending, level and reserved modes.

// File: rtl/ext_irq_pkg.sv
// Shared types for the external pin interrupt controller.
// Assumes: sense fields are two bits wide per source.
package ext_irq_pkg;

    typedef enum logic [1:0] {
        SNS_LOW  = 2'b00,
        SNS_RSVD = 2'b01,
        SNS_FALL = 2'b10,
        SNS_RISE = 2'b11
    } sense_e;

    // Edge modes are exactly the encodings with the upper bit set.
    function automatic logic sense_is_edge(input logic [1:0] s);
        return s[1];
    endfunction

endpackage

// File: rtl/ext_irq_sync.sv
// Per-source pin synchroniser and edge detector.
// Each pin goes through STAGES flops; the last stage is compared with one
// further flop to produce single-cycle rise and fall pulses.
// Assumes: STAGES >= 2; all flops clear to 0 on reset.
module ext_irq_sync #(
    parameter int N_SRC  = 2,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] pin_i,
    output logic [N_SRC-1:0] lvl_o,
    output logic [N_SRC-1:0] rise_o,
    output logic [N_SRC-1:0] fall_o
);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        logic [STAGES-1:0] chain_q;
        logic              prev_q;

        // Shift the raw pin through the chain and keep the previous level.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                chain_q <= '0;
                prev_q  <= 1'b0;
            end else begin
                chain_q <= {chain_q[STAGES-2:0], pin_i[g]};
                prev_q  <= chain_q[STAGES-1];
            end
        end

        assign lvl_o[g]  = chain_q[STAGES-1];
        assign rise_o[g] = chain_q[STAGES-1] & ~prev_q;
        assign fall_o[g] = ~chain_q[STAGES-1] & prev_q;
    end

endmodule

// File: rtl/ext_irq_flags.sv
// Pending flags for edge-sensed sources.
// A flag sets on an edge of the polarity picked by the sense field. It clears
// on clr_i, but a same-cycle set wins. It is held at 0 in level or reserved mode.
// Assumes: rise_i/fall_i are single-cycle pulses from the synchroniser.
module ext_irq_flags #(
    parameter int N_SRC = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [2*N_SRC-1:0] sense_i,
    input  logic [N_SRC-1:0]   rise_i,
    input  logic [N_SRC-1:0]   fall_i,
    input  logic [N_SRC-1:0]   clr_i,
    output logic [N_SRC-1:0]   flag_o
);
    import ext_irq_pkg::*;

    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        sense_e mode;
        logic   set;
        logic   flag_q;

        assign mode = sense_e'(sense_i[2*g +: 2]);

        // Pick the edge pulse that matches the selected polarity.
        always_comb begin
            unique case (mode)
                SNS_RISE: set = rise_i[g];
                SNS_FALL: set = fall_i[g];
                default:  set = 1'b0;
            endcase
        end

        // Latch, clear or force the flag to zero depending on the mode.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                flag_q <= 1'b0;
            end else if (!sense_is_edge(mode)) begin
                flag_q <= 1'b0;
            end else begin
                flag_q <= set | (flag_q & ~clr_i[g]);
            end
        end

        assign flag_o[g] = flag_q;
    end

endmodule

// File: rtl/ext_irq_regs.sv
// Mask register, flag write-one-to-clear decode and read mux.
// Source i sits at data bit BIT_BASE+i of both registers; other bits read 0.
// Assumes: BIT_BASE + N_SRC <= DATA_W; reads are purely combinational.
module ext_irq_regs #(
    parameter int                N_SRC     = 2,
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                BIT_BASE  = 6,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_wr_i,
    input  logic [ADDR_W-1:0] io_addr_i,
    input  logic [DATA_W-1:0] io_wdata_i,
    input  logic [N_SRC-1:0]  flag_i,
    output logic [N_SRC-1:0]  mask_o,
    output logic [N_SRC-1:0]  sw_clr_o,
    output logic [DATA_W-1:0] io_rdata_o
);

    logic [N_SRC-1:0] mask_q;
    logic             hit_mask;
    logic             hit_flag;

    assign hit_mask = (io_addr_i == MASK_ADDR);
    assign hit_flag = (io_addr_i == FLAG_ADDR);

    // Load the enable bits on a write to the mask address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (io_wr_i && hit_mask) begin
            mask_q <= io_wdata_i[BIT_BASE +: N_SRC];
        end
    end

    // A write of 1 to a flag bit requests its clear; 0 bits do nothing.
    assign sw_clr_o = {N_SRC{io_wr_i && hit_flag}} & io_wdata_i[BIT_BASE +: N_SRC];

    // Place the addressed register's bits at their positions, rest zero.
    always_comb begin
        io_rdata_o = '0;
        if (hit_mask) begin
            io_rdata_o[BIT_BASE +: N_SRC] = mask_q;
        end else if (hit_flag) begin
            io_rdata_o[BIT_BASE +: N_SRC] = flag_i;
        end
    end

    assign mask_o = mask_q;

endmodule

// File: rtl/ext_irq_arb.sv
// Fixed-priority arbiter: the lowest-numbered requesting source wins.
// The vector is index+1, so 0 means no request. The grant is one-hot or zero.
// Assumes: VEC_W can hold N_SRC.
module ext_irq_arb #(
    parameter int N_SRC = 2,
    parameter int VEC_W = 2
) (
    input  logic [N_SRC-1:0] req_i,
    output logic             irq_o,
    output logic [VEC_W-1:0] vec_o,
    output logic [N_SRC-1:0] grant_o
);

    // Scan from the highest index down so the lowest request is the last to win.
    always_comb begin
        vec_o   = '0;
        grant_o = '0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                vec_o      = VEC_W'(i + 1);
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
    end

    assign irq_o = |req_i;

endmodule

// File: rtl/ext_irq_ctrl.sv
// External pin interrupt controller top.
// Synchronises the pins, latches edge flags, forms per-source pending
// (the flag in edge modes, the low level in level mode, nothing in reserved
// mode), gates it with mask and global enable, and arbitrates to a vector.
// ack_i clears the flag of the source being presented.
// Assumes: sense_i and gie_i come from registers in the core's clock domain.
module ext_irq_ctrl #(
    parameter int                N_SRC     = 2,
    parameter int                SYNC_STG  = 2,
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                BIT_BASE  = 6,
    parameter logic [ADDR_W-1:0] MASK_ADDR = 6'h3B,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A,
    localparam int               VEC_W     = $clog2(N_SRC + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_SRC-1:0]   pin_i,
    input  logic [2*N_SRC-1:0] sense_i,
    input  logic               gie_i,
    input  logic               ack_i,
    input  logic               io_wr_i,
    input  logic [ADDR_W-1:0]  io_addr_i,
    input  logic [DATA_W-1:0]  io_wdata_i,
    output logic [DATA_W-1:0]  io_rdata_o,
    output logic               irq_o,
    output logic [VEC_W-1:0]   vec_o
);
    import ext_irq_pkg::*;

    logic [N_SRC-1:0] lvl, rise, fall;
    logic [N_SRC-1:0] flag_q, mask_q;
    logic [N_SRC-1:0] sw_clr, ack_clr, grant;
    logic [N_SRC-1:0] pend, req;

    ext_irq_sync #(.N_SRC(N_SRC), .STAGES(SYNC_STG)) sync_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (pin_i),
        .lvl_o  (lvl),
        .rise_o (rise),
        .fall_o (fall)
    );

    ext_irq_flags #(.N_SRC(N_SRC)) flags_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .sense_i (sense_i),
        .rise_i  (rise),
        .fall_i  (fall),
        .clr_i   (sw_clr | ack_clr),
        .flag_o  (flag_q)
    );

    ext_irq_regs #(
        .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE),
        .MASK_ADDR(MASK_ADDR), .FLAG_ADDR(FLAG_ADDR)
    ) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .io_wr_i    (io_wr_i),
        .io_addr_i  (io_addr_i),
        .io_wdata_i (io_wdata_i),
        .flag_i     (flag_q),
        .mask_o     (mask_q),
        .sw_clr_o   (sw_clr),
        .io_rdata_o (io_rdata_o)
    );

    // Per-source pending according to its sense mode.
    for (genvar g = 0; g < N_SRC; g++) begin : g_pend
        sense_e mode;
        assign mode = sense_e'(sense_i[2*g +: 2]);

        // Level mode follows the inverted pin; edge modes use the flag.
        always_comb begin
            unique case (mode)
                SNS_LOW:  pend[g] = ~lvl[g];
                SNS_RSVD: pend[g] = 1'b0;
                default:  pend[g] = flag_q[g];
            endcase
        end
    end

    assign req     = pend & mask_q & {N_SRC{gie_i}};
    assign ack_clr = {N_SRC{ack_i}} & grant;

    ext_irq_arb #(.N_SRC(N_SRC), .VEC_W(VEC_W)) arb_i (
        .req_i   (req),
        .irq_o   (irq_o),
        .vec_o   (vec_o),
        .grant_o (grant)
    );

endmodule

// File: rtl/ext_irq_chk.sv
// Property checker for ext_irq_ctrl, attached by bind below.
// Assumes: BIT_BASE >= 1 so that low reserved bits exist.
module ext_irq_chk #(
    parameter int                N_SRC     = 2,
    parameter int                ADDR_W    = 6,
    parameter int                DATA_W    = 8,
    parameter int                BIT_BASE  = 6,
    parameter logic [ADDR_W-1:0] FLAG_ADDR = 6'h3A,
    parameter int                VEC_W     = 2
) (
    input logic               clk,
    input logic               rst_n,
    input logic [2*N_SRC-1:0] sense_i,
    input logic               gie_i,
    input logic               ack_i,
    input logic               io_wr_i,
    input logic [ADDR_W-1:0]  io_addr_i,
    input logic [DATA_W-1:0]  io_wdata_i,
    input logic [DATA_W-1:0]  io_rdata_o,
    input logic               irq_o,
    input logic [VEC_W-1:0]   vec_o,
    input logic [N_SRC-1:0]   flag_q
);

    // R7
    gie_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> gie_i);

    // R10
    vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (vec_o != '0 && int'(vec_o) <= N_SRC));

    // R10
    vec_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_o |-> vec_o == '0);

    // R2
    rsvd_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        io_rdata_o[BIT_BASE-1:0] == '0);

    for (genvar g = 0; g < N_SRC; g++) begin : g_src
        // R5
        level_flag_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !sense_i[2*g+1] |=> !flag_q[g]);

        // R8
        wr0_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flag_q[g] && sense_i[2*g+1] && !ack_i &&
             !(io_wr_i && io_addr_i == FLAG_ADDR && io_wdata_i[BIT_BASE+g]))
            |=> flag_q[g]);
    end

endmodule

bind ext_irq_ctrl ext_irq_chk #(
    .N_SRC(N_SRC), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_BASE(BIT_BASE),
    .FLAG_ADDR(FLAG_ADDR), .VEC_W(VEC_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .sense_i    (sense_i),
    .gie_i      (gie_i),
    .ack_i      (ack_i),
    .io_wr_i    (io_wr_i),
    .io_addr_i  (io_addr_i),
    .io_wdata_i (io_wdata_i),
    .io_rdata_o (io_rdata_o),
    .irq_o      (irq_o),
    .vec_o      (vec_o),
    .flag_q     (flag_q)
);

// File: tb/ext_irq_ctrl_tb_top.sv
// Bench for ext_irq_ctrl: directed corner cases, then seeded random stimulus,
// all compared every cycle with a cycle-level model built from the requirements.
module ext_irq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam logic [5:0] A_MASK = 6'h3B;
    localparam logic [5:0] A_FLAG = 6'h3A;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pin_i = '0;
    logic [3:0] sense_i = '0;
    logic       gie_i = 1'b0;
    logic       ack_i = 1'b0;
    logic       io_wr_i = 1'b0;
    logic [5:0] io_addr_i = '0;
    logic [7:0] io_wdata_i = '0;
    logic [7:0] io_rdata_o;
    logic       irq_o;
    logic [1:0] vec_o;

    int    n_checks = 0;
    int    n_errors = 0;
    bit    done = 1'b0;
    string cur_tag = "R1";

    always #(CLK_PERIOD/2) clk = ~clk;

    ext_irq_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .sense_i(sense_i),
        .gie_i(gie_i), .ack_i(ack_i), .io_wr_i(io_wr_i), .io_addr_i(io_addr_i),
        .io_wdata_i(io_wdata_i), .io_rdata_o(io_rdata_o), .irq_o(irq_o), .vec_o(vec_o)
    );

    // ---------------- reference model ----------------
    logic [1:0] m_s1 = '0, m_s2 = '0, m_prev = '0, m_flag = '0, m_mask = '0;

    function automatic logic [1:0] m_req();
        logic [1:0] p;
        for (int i = 0; i < 2; i++) begin
            case (sense_i[2*i +: 2])
                2'b00:   p[i] = ~m_s2[i];
                2'b01:   p[i] = 1'b0;
                default: p[i] = m_flag[i];
            endcase
        end
        return p & m_mask & {2{gie_i}};
    endfunction

    function automatic logic [1:0] m_vec();
        logic [1:0] r = m_req();
        return r[0] ? 2'd1 : (r[1] ? 2'd2 : 2'd0);
    endfunction

    function automatic logic [7:0] m_rdata();
        if (io_addr_i == A_MASK) return {m_mask, 6'b0};
        if (io_addr_i == A_FLAG) return {m_flag, 6'b0};
        return 8'h00;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0; m_flag <= '0; m_mask <= '0;
        end else begin
            logic [1:0] vcur;
            vcur = m_vec();
            m_s1 <= pin_i;
            m_s2 <= m_s1;
            m_prev <= m_s2;
            if (io_wr_i && io_addr_i == A_MASK) m_mask <= io_wdata_i[7:6];
            for (int i = 0; i < 2; i++) begin
                logic rs, fl, st, cl;
                rs = m_s2[i] & ~m_prev[i];
                fl = ~m_s2[i] & m_prev[i];
                st = (sense_i[2*i +: 2] == 2'b11) ? rs :
                     (sense_i[2*i +: 2] == 2'b10) ? fl : 1'b0;
                cl = (io_wr_i && io_addr_i == A_FLAG && io_wdata_i[6+i]) ||
                     (ack_i && vcur == 2'(i + 1));
                m_flag[i] <= sense_i[2*i+1] ? (st | (m_flag[i] & ~cl)) : 1'b0;
            end
        end
    end

    // ---------------- checking ----------------
    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait to just before the next edge, compare with the model, move to the negedge.
    task automatic step();
        #(CLK_PERIOD/2 - 1);
        if (rst_n) begin
            check({cur_tag, " irq"}, {7'b0, irq_o}, {7'b0, |m_req()});
            check({cur_tag, " vec"}, {6'b0, vec_o}, {6'b0, m_vec()});
            check({cur_tag, " rdata"}, io_rdata_o, m_rdata());
        end
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) step();
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        io_wr_i = 1'b1; io_addr_i = a; io_wdata_i = d;
        step();
        io_wr_i = 1'b0;
    endtask

    task automatic rd_expect(input string tag, input logic [5:0] a, input logic [7:0] e);
        io_addr_i = a;
        #(CLK_PERIOD/2 - 1);
        check(tag, io_rdata_o, e);
        @(negedge clk);
    endtask

    task automatic out_expect(input string tag, input logic i, input logic [1:0] v);
        #(CLK_PERIOD/2 - 1);
        check({tag, " irq"}, {7'b0, irq_o}, {7'b0, i});
        check({tag, " vec"}, {6'b0, vec_o}, {6'b0, v});
        @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        idle(3);
        // R1: reset state
        out_expect("R1", 1'b0, 2'd0);
        rd_expect("R1 mask", A_MASK, 8'h00);
        rd_expect("R1 flag", A_FLAG, 8'h00);
        rst_n = 1'b1;
        sense_i = 4'b1111;
        gie_i = 1'b1;
        idle(4);
        rd_expect("R1 flag after release", A_FLAG, 8'h00);

        // R2: register map and reserved bits
        cur_tag = "R2";
        wr(A_MASK, 8'hFF);
        rd_expect("R2 mask all", A_MASK, 8'hC0);
        rd_expect("R2 other addr", 6'h10, 8'h00);
        wr(A_MASK, 8'h00);
        rd_expect("R2 mask clear", A_MASK, 8'h00);

        // R4: rising edge latches even when masked; R7 no request while masked
        cur_tag = "R4";
        pin_i[0] = 1'b1;
        idle(3);
        rd_expect("R4 flag0 rise masked", A_FLAG, 8'h40);
        out_expect("R7 masked", 1'b0, 2'd0);
        cur_tag = "R7";
        gie_i = 1'b0;
        wr(A_MASK, 8'h40);
        out_expect("R7 gie off", 1'b0, 2'd0);
        gie_i = 1'b1;
        out_expect("R7 gie on", 1'b1, 2'd1);

        // R8: write 0 keeps, write 1 clears
        cur_tag = "R8";
        wr(A_FLAG, 8'h00);
        rd_expect("R8 write0 keeps", A_FLAG, 8'h40);
        wr(A_FLAG, 8'h40);
        rd_expect("R8 write1 clears", A_FLAG, 8'h00);

        // R3/R10/R9: falling on source 0, rising on source 1, both pending
        cur_tag = "R10";
        sense_i = 4'b1110;
        wr(A_MASK, 8'hC0);
        pin_i = 2'b10;
        idle(3);
        rd_expect("R3 both flags", A_FLAG, 8'hC0);
        out_expect("R10 source0 wins", 1'b1, 2'd1);
        cur_tag = "R9";
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        rd_expect("R9 ack clears only source0", A_FLAG, 8'h80);
        out_expect("R10 source1 next", 1'b1, 2'd2);
        ack_i = 1'b1;
        step();
        ack_i = 1'b0;
        out_expect("R9 all acked", 1'b0, 2'd0);

        // R5: level mode on source 0 (pin low), flag stays 0
        cur_tag = "R5";
        sense_i = 4'b1100;
        step();
        out_expect("R5 low level requests", 1'b1, 2'd1);
        rd_expect("R5 flag zero", A_FLAG, 8'h00);
        pin_i[0] = 1'b1;
        idle(1);
        out_expect("R5 still before sync", 1'b1, 2'd1);
        out_expect("R5 released", 1'b0, 2'd0);

        // R6: reserved mode never requests
        cur_tag = "R6";
        sense_i = 4'b1101;
        pin_i[0] = 1'b0;
        idle(4);
        out_expect("R6 reserved no irq", 1'b0, 2'd0);
        rd_expect("R6 flag zero", A_FLAG, 8'h00);

        // Random phase: R3 R4 R5 R8 R9 R10 via model comparison
        cur_tag = "R3/R4/R5/R8/R9/R10 random";
        for (int c = 0; c < 6000; c++) begin
            if ($urandom_range(3) == 0) pin_i[0] = ~pin_i[0];
            if ($urandom_range(3) == 0) pin_i[1] = ~pin_i[1];
            if ($urandom_range(40) == 0) sense_i = 4'($urandom);
            if ($urandom_range(20) == 0) gie_i = ~gie_i;
            ack_i = ($urandom_range(4) == 0);
            io_wr_i = ($urandom_range(3) == 0);
            case ($urandom_range(3))
                0, 1:    io_addr_i = A_FLAG;
                2:       io_addr_i = A_MASK;
                default: io_addr_i = 6'($urandom);
            endcase
            io_wdata_i = 8'($urandom);
            if (io_addr_i == A_MASK && $urandom_range(1) == 0) io_wdata_i[7:6] = 2'b11;
            step();
        end
        io_wr_i = 1'b0;
        ack_i = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule